// File: doc/BRIEF.md
# Burst Transceiver Power Sequencer

This block switches the transmit and receive halves of a half-duplex burst modem front end on and off around each burst. It runs on the transmit sample clock. It watches a transmit-enable pin and a receive-enable pin, and it drives three power enables: one for the transmit converter, one for the transmit amplifier and one for the receive chain. A transmit burst powers the transmit side up at once. When the burst ends, the block first forces the sample stream into the interpolation filter to the midscale code for a fixed flush window. It then holds the transmit power on for a programmable number of clocks, so that the last samples leave the pipeline before the converter shuts off.

The receive side follows one of the two enable pins, chosen by a mode bit. Separate mode bits can disable fast power-down for each direction. An 8-bit control word holds these settings and is written with a strobe:

- delay in bits [7:3]
- receive-source select in bit 2
- transmit fast power-down in bit 1
- receive fast power-down in bit 0

Each path also has a ready flag that rises a fixed number of clocks after its power comes on. The flag stands in for analog settling time.

Both enable pins pass through a two-flop synchronizer and then a registered edge detector. An edge therefore takes effect on the fourth rising clock edge after the pin changes. The first rising edge that samples the new level counts as the first of the four.

The transmit state machine has four states:

- TX_OFF goes to TX_ON on a transmit-enable rise (power-up).
- TX_ON goes to TX_FLUSH on a transmit-enable fall, when transmit fast power-down is set (start drain).
- TX_FLUSH goes to TX_HOLD when the flush window ends with a nonzero delay (flush done).
- TX_FLUSH goes to TX_OFF when the flush window ends with a zero delay (flush done, no hold).
- TX_HOLD goes to TX_OFF when the delay count ends (power-down).
- TX_FLUSH goes to TX_ON, and TX_HOLD goes to TX_ON, on a transmit-enable rise (cancel).

The receive state machine has two states:

- RX_OFF goes to RX_ON on the power-up edge of the selected pin (rx wake).
- RX_ON goes to RX_OFF on its power-down edge, when receive fast power-down is set (rx sleep).

Top module: `bpwr_seq_top`

## Requirements
- R1: After reset all power enables, flush_req, tx_ready and rx_ready are 0, dout equals din, and the control word is 0xFB. That value means a delay of 31, receive controlled by tx_en, and both fast power-downs enabled.
- R2: A rise of tx_en raises tx_dac_pwr and tx_amp_pwr on the fourth rising clock edge after the pin change, with no programmed delay.
- R3: A fall of tx_en while transmit is powered, with bit 1 set, asserts flush_req for exactly 33 cycles, starting on the fourth edge. While flush_req is high, dout is the midscale code (MSB 1, all other bits 0); at all other times dout equals din.
- R4: After the flush window the transmit enables stay high for D more cycles and then drop, where D is the delay field in bits [7:3]. With D = 0 they drop on the same edge as flush_req.
- R5: A rise of tx_en taking effect during the flush window or the delay hold ends the flush at once and keeps the transmit path powered.
- R6: With bit 1 clear, a fall of tx_en is ignored: there is no flush, and the transmit path stays powered.
- R7: With bit 2 clear, a fall of tx_en powers the receive chain up and a rise of tx_en powers it down, with the same four-edge latency.
- R8: With bit 2 set, a rise of rx_en powers the receive chain up and a fall powers it down, and tx_en edges do not affect rx_pwr.
- R9: With bit 0 clear, the power-down edge of the selected receive source is ignored and rx_pwr stays high.
- R10: tx_ready rises exactly TX_SETTLE cycles after the transmit power rises, and rx_ready rises exactly RX_SETTLE cycles after rx_pwr rises. Each flag falls on the same edge as its power enable.
- R11: A rising clock edge with cfg_we high loads cfg_wdata into the control word, and the new settings govern the following edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit burst enable, asynchronous |
| rx_en | input | 1 | Receive enable, asynchronous |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | CFG_W (8) | Control word: delay [7:3], rx source bit 2, tx fast bit 1, rx fast bit 0 |
| din | input | DATA_W (12) | Sample stream toward the interpolation filter |
| tx_dac_pwr | output | 1 | Transmit converter power enable |
| tx_amp_pwr | output | 1 | Transmit amplifier power enable |
| rx_pwr | output | 1 | Receive chain power enable |
| flush_req | output | 1 | Flush window active |
| dout | output | DATA_W (12) | din, or the midscale code during flush |
| tx_ready | output | 1 | Transmit path settled |
| rx_ready | output | 1 | Receive path settled |

## Verification
With the receive chain following tx_en, one registered rise of tx_en does two things on the same edge: it cancels a running transmit flush or delay hold, and it powers the receive chain down. The bench provokes this with directed bursts that re-raise tx_en a few cycles into the flush. It also uses random enable toggling with random control words, which often lands rises inside the drain window. A bench model driven only by the pin history and the control word judges every cycle. It predicts both power enables, flush_req, dout and the ready flags, so a wrong result on either side of the shared edge shows up as a mismatch.

// File: rtl/bpwr_pkg.sv
package bpwr_pkg;

    typedef enum logic [1:0] {
        TX_OFF   = 2'd0,
        TX_ON    = 2'd1,
        TX_FLUSH = 2'd2,
        TX_HOLD  = 2'd3
    } tx_state_e;

    typedef enum logic {
        RX_OFF = 1'b0,
        RX_ON  = 1'b1
    } rx_state_e;

    // control word bit positions
    localparam int CFG_RXFAST_BIT = 0;
    localparam int CFG_TXFAST_BIT = 1;
    localparam int CFG_RXSEL_BIT  = 2;
    localparam int CFG_DLY_LSB    = 3;

    // edge-detector channel indices
    localparam int SRC_TX = 0;
    localparam int SRC_RX = 1;

endpackage

// File: rtl/bpwr_edge_sync.sv
module bpwr_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar g = 0; g < N; g++) begin : g_ch
        logic s1, s2, s3, r_q, f_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1  <= 1'b0;
                s2  <= 1'b0;
                s3  <= 1'b0;
                r_q <= 1'b0;
                f_q <= 1'b0;
            end else begin
                s1  <= lvl[g];
                s2  <= s1;
                s3  <= s2;
                r_q <= s2 & ~s3;
                f_q <= ~s2 & s3;
            end
        end

        assign rise[g] = r_q;
        assign fall[g] = f_q;

        a_r2_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(r_q && f_q));
    end

endmodule

// File: rtl/bpwr_tx_fsm.sv
module bpwr_tx_fsm
    import bpwr_pkg::*;
#(
    parameter int DLY_W     = 5,
    parameter int FLUSH_LEN = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             fast,
    input  logic [DLY_W-1:0] delay,
    output logic             dac_pwr,
    output logic             amp_pwr,
    output logic             flush
);

    localparam int FL_W  = $clog2(FLUSH_LEN);
    localparam int CNT_W = (FL_W > DLY_W) ? FL_W : DLY_W;
    localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(FLUSH_LEN - 1);

    tx_state_e        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [DLY_W-1:0] lim;
    logic             flush_done, hold_done;

    assign flush_done = (cnt == FLUSH_LAST);
    assign hold_done  = (cnt == (CNT_W'(lim) - CNT_W'(1)));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            TX_OFF:   if (rise) nxt = TX_ON;
            TX_ON:    if (fall && fast) nxt = TX_FLUSH;
            TX_FLUSH: begin
                if (rise)            nxt = TX_ON;
                else if (flush_done) nxt = (lim == '0) ? TX_OFF : TX_HOLD;
            end
            TX_HOLD: begin
                if (rise)           nxt = TX_ON;
                else if (hold_done) nxt = TX_OFF;
            end
        endcase
    end

    // state register, window counter, latched delay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_OFF;
            cnt   <= '0;
            lim   <= '0;
        end else begin
            state <= nxt;
            if (state != nxt)
                cnt <= '0;
            else if (state == TX_FLUSH || state == TX_HOLD)
                cnt <= cnt + CNT_W'(1);
            if (state == TX_ON && nxt == TX_FLUSH)
                lim <= delay;
        end
    end

    // outputs
    always_comb begin
        dac_pwr = 1'b0;
        amp_pwr = 1'b0;
        flush   = 1'b0;
        unique case (state)
            TX_OFF:   ;
            TX_ON:    begin dac_pwr = 1'b1; amp_pwr = 1'b1; end
            TX_FLUSH: begin dac_pwr = 1'b1; amp_pwr = 1'b1; flush = 1'b1; end
            TX_HOLD:  begin dac_pwr = 1'b1; amp_pwr = 1'b1; end
        endcase
    end

    a_r2_power_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_OFF && rise) |=> (dac_pwr && amp_pwr));

    a_r3_flush_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_FLUSH) |-> (cnt < CNT_W'(FLUSH_LEN)));

    a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == TX_FLUSH || state == TX_HOLD) && rise) |=> (state == TX_ON && !flush));

    a_r6_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_ON && !fast) |=> dac_pwr);

endmodule

// File: rtl/bpwr_rx_fsm.sv
module bpwr_rx_fsm
    import bpwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rise,
    input  logic tx_fall,
    input  logic rx_rise,
    input  logic rx_fall,
    input  logic by_rxen,
    input  logic fast,
    output logic pwr
);

    rx_state_e state, nxt;
    logic      up, down;

    assign up   = by_rxen ? rx_rise : tx_fall;
    assign down = by_rxen ? rx_fall : tx_rise;

    always_comb begin
        nxt = state;
        unique case (state)
            RX_OFF: if (up) nxt = RX_ON;
            RX_ON:  if (down && fast) nxt = RX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_OFF;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            RX_OFF: pwr = 1'b0;
            RX_ON:  pwr = 1'b1;
        endcase
    end

    a_r8_rxen_only: assert property (@(posedge clk) disable iff (!rst_n)
        (by_rxen && state == RX_OFF && !rx_rise) |=> !pwr);

    a_r9_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_ON && !fast) |=> pwr);

endmodule

// File: rtl/bpwr_settle.sv
module bpwr_settle #(
    parameter int CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    output logic ready
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!pwr)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + CW'(1);
    end

    assign ready = pwr && (cnt == LAST);

    a_r10_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    a_r10_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(pwr));

endmodule

// File: rtl/bpwr_seq_top.sv
module bpwr_seq_top
    import bpwr_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int DLY_W     = 5,
    parameter int FLUSH_LEN = 33,
    parameter int TX_SETTLE = 25,
    parameter int RX_SETTLE = 100,
    localparam int CFG_W    = DLY_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [DATA_W-1:0] din,
    output logic              tx_dac_pwr,
    output logic              tx_amp_pwr,
    output logic              rx_pwr,
    output logic              flush_req,
    output logic [DATA_W-1:0] dout,
    output logic              tx_ready,
    output logic              rx_ready
);

    localparam logic [CFG_W-1:0]  CFG_RESET = {{DLY_W{1'b1}}, 3'b011};
    localparam logic [DATA_W-1:0] MIDSCALE  = {1'b1, {(DATA_W-1){1'b0}}};

    logic [CFG_W-1:0] cfg_q;
    logic [1:0]       rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    bpwr_edge_sync #(.N(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({rx_en, tx_en}),
        .rise (rise),
        .fall (fall)
    );

    bpwr_tx_fsm #(.DLY_W(DLY_W), .FLUSH_LEN(FLUSH_LEN)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise[SRC_TX]),
        .fall   (fall[SRC_TX]),
        .fast   (cfg_q[CFG_TXFAST_BIT]),
        .delay  (cfg_q[CFG_DLY_LSB +: DLY_W]),
        .dac_pwr(tx_dac_pwr),
        .amp_pwr(tx_amp_pwr),
        .flush  (flush_req)
    );

    bpwr_rx_fsm u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_rise(rise[SRC_TX]),
        .tx_fall(fall[SRC_TX]),
        .rx_rise(rise[SRC_RX]),
        .rx_fall(fall[SRC_RX]),
        .by_rxen(cfg_q[CFG_RXSEL_BIT]),
        .fast   (cfg_q[CFG_RXFAST_BIT]),
        .pwr    (rx_pwr)
    );

    bpwr_settle #(.CYCLES(TX_SETTLE)) u_tx_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .pwr  (tx_dac_pwr),
        .ready(tx_ready)
    );

    bpwr_settle #(.CYCLES(RX_SETTLE)) u_rx_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .pwr  (rx_pwr),
        .ready(rx_ready)
    );

    assign dout = flush_req ? MIDSCALE : din;

    a_r11_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_wdata)));

    a_r4_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dac_pwr == tx_amp_pwr);

endmodule

// File: tb/bpwr_seq_top_bench.sv
module bpwr_seq_top_bench;

    localparam int CLK_NS = 10;
    localparam int DW     = 12;
    localparam int TXS    = 25;
    localparam int RXS    = 100;
    localparam int FL     = 33;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0, rx_en = 1'b0, cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [DW-1:0] din = '0;
    logic          tx_dac_pwr, tx_amp_pwr, rx_pwr, flush_req, tx_ready, rx_ready;
    logic [DW-1:0] dout;

    bpwr_seq_top u_bpwr_seq_top (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .din(din),
        .tx_dac_pwr(tx_dac_pwr), .tx_amp_pwr(tx_amp_pwr), .rx_pwr(rx_pwr),
        .flush_req(flush_req), .dout(dout), .tx_ready(tx_ready), .rx_ready(rx_ready)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    function automatic logic [DW-1:0] midcode();
        return {1'b1, {(DW-1){1'b0}}};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit [7:0] m_cfg = 8'hFB;
    int m_tx = 0, m_cnt = 0, m_lim = 0, m_tsc = 0, m_rsc = 0;
    bit m_rx = 0;
    bit t1, t2, t3, t4, r1, r2, r3, r4;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 8'hFB; m_tx = 0; m_cnt = 0; m_lim = 0; m_rx = 0; m_tsc = 0; m_rsc = 0;
            {t1, t2, t3, t4, r1, r2, r3, r4} = '0;
        end else begin
            bit tr, tf, rr, rf, up, dn;
            tr = t3 & ~t4; tf = ~t3 & t4;
            rr = r3 & ~r4; rf = ~r3 & r4;
            if (m_tx == 0) m_tsc = 0; else if (m_tsc < TXS) m_tsc++;
            if (!m_rx)     m_rsc = 0; else if (m_rsc < RXS) m_rsc++;
            case (m_tx)
                0: if (tr) m_tx = 1;
                1: if (tf && m_cfg[1]) begin m_tx = 2; m_cnt = 0; m_lim = int'(m_cfg[7:3]); end
                2: if (tr) m_tx = 1;
                   else if (m_cnt == FL - 1) begin m_tx = (m_lim == 0) ? 0 : 3; m_cnt = 0; end
                   else m_cnt++;
                default: if (tr) m_tx = 1;
                   else if (m_cnt == m_lim - 1) m_tx = 0;
                   else m_cnt++;
            endcase
            up = m_cfg[2] ? rr : tf;
            dn = m_cfg[2] ? rf : tr;
            if (up) m_rx = 1; else if (dn && m_cfg[0]) m_rx = 0;
            t4 = t3; t3 = t2; t2 = t1; t1 = tx_en;
            r4 = r3; r3 = r2; r2 = r1; r1 = rx_en;
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit etx, efl;
            etx = (m_tx != 0);
            efl = (m_tx == 2);
            chk("R2", "tx_dac_pwr", 32'(tx_dac_pwr), 32'(etx));
            chk("R4", "tx_amp_pwr", 32'(tx_amp_pwr), 32'(etx));
            chk("R3", "flush_req",  32'(flush_req),  32'(efl));
            chk("R3", "dout",       32'(dout),       32'(efl ? midcode() : din));
            chk("R7", "rx_pwr",     32'(rx_pwr),     32'(m_rx));
            chk("R10", "tx_ready",  32'(tx_ready),   32'(etx && m_tsc == TXS));
            chk("R10", "rx_ready",  32'(rx_ready),   32'(m_rx && m_rsc == RXS));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drv_tx(bit v);
        @(negedge clk); #1; tx_en = v;
    endtask
    task automatic drv_rx(bit v);
        @(negedge clk); #1; rx_en = v;
    endtask
    task automatic wr_cfg(logic [7:0] v);
        @(negedge clk); #1; cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); #1; cfg_we = 1'b0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    // negedges until signal sel is high (0 tx_dac, 1 flush, 2 rx, 3 tx_ready), bounded
    task automatic wait_hi(int sel, output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!(sel == 0 ? tx_dac_pwr : sel == 1 ? flush_req :
                     sel == 2 ? rx_pwr : tx_ready) && n < 300);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int n, c;
        void'($urandom(32'h5EED_0042));
        // R1: reset state
        #(CLK_NS * 3 + 2);
        din = 12'h3A5;
        #1;
        chk("R1", "tx_dac_pwr", 32'(tx_dac_pwr), 0);
        chk("R1", "rx_pwr",     32'(rx_pwr), 0);
        chk("R1", "flush_req",  32'(flush_req), 0);
        chk("R1", "ready",      32'({tx_ready, rx_ready}), 0);
        chk("R1", "dout",       32'(dout), 32'h3A5);
        @(negedge clk); #1; rst_n = 1'b1; cmp_on = 1'b1;
        idle(3);

        // R2: rise latency 4 edges
        drv_tx(1'b1);
        wait_hi(0, n);
        chk("R2", "tx up latency", 32'(n), 4);
        // R10: ready after TX_SETTLE
        wait_hi(3, n);
        chk("R10", "tx settle", 32'(n), TXS);
        // R3/R4 with default delay 31 (R1 reset control word)
        drv_tx(1'b0);
        wait_hi(1, n);
        chk("R3", "flush latency", 32'(n), 4);
        chk("R3", "midscale", 32'(dout), 32'(midcode()));
        c = 0;
        while (flush_req && c < 100) begin c++; @(negedge clk); end
        chk("R3", "flush length", 32'(c), FL);
        c = 0;
        while (tx_dac_pwr && c < 100) begin c++; @(negedge clk); end
        chk("R1", "default hold", 32'(c), 31);
        chk("R7", "rx on after tx burst", 32'(rx_pwr), 1);

        // R11 + R4: delay 5, then delay 0
        wr_cfg({5'd5, 3'b011});
        drv_tx(1'b1); idle(10); drv_tx(1'b0);
        wait_hi(1, n);
        c = 0;
        while (flush_req && c < 100) begin c++; @(negedge clk); end
        c = 0;
        while (tx_dac_pwr && c < 100) begin c++; @(negedge clk); end
        chk("R11", "hold with delay 5", 32'(c), 5);
        wr_cfg({5'd0, 3'b011});
        drv_tx(1'b1); idle(10); drv_tx(1'b0);
        wait_hi(1, n);
        c = 0;
        while (flush_req && c < 100) begin c++; @(negedge clk); end
        chk("R4", "zero delay drop", 32'(tx_dac_pwr), 0);

        // R5: cancel mid-flush (rx powers down on same edge)
        wr_cfg({5'd20, 3'b011});
        drv_tx(1'b1); idle(10); drv_tx(1'b0);
        wait_hi(1, n); idle(5);
        drv_tx(1'b1); idle(4);
        chk("R5", "flush cancelled", 32'(flush_req), 0);
        chk("R5", "tx kept on", 32'(tx_dac_pwr), 1);
        chk("R7", "rx down on tx rise", 32'(rx_pwr), 0);
        idle(80);
        chk("R5", "tx still on", 32'(tx_dac_pwr), 1);

        // R6: tx fast disabled
        wr_cfg({5'd3, 3'b001});
        drv_tx(1'b0); idle(100);
        chk("R6", "tx stays on", 32'(tx_dac_pwr), 1);
        chk("R6", "no flush", 32'(flush_req), 0);

        // R8: rx follows rx_en
        wr_cfg({5'd3, 3'b111});
        drv_tx(1'b1); idle(8);
        drv_tx(1'b0); idle(60);
        chk("R8", "tx_en no effect on rx", 32'(rx_pwr), 1);
        drv_rx(1'b1); idle(8);
        drv_rx(1'b0);
        idle(4);
        chk("R8", "rx down on rx_en fall", 32'(rx_pwr), 0);
        drv_rx(1'b1);
        wait_hi(2, n);
        chk("R8", "rx up latency", 32'(n), 4);

        // R9: rx fast disabled
        wr_cfg({5'd3, 3'b110});
        drv_rx(1'b0); idle(20);
        chk("R9", "rx stays on", 32'(rx_pwr), 1);

        // constrained random
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk); #1;
            din = DW'($urandom);
            if ($urandom_range(0, 39) == 0) tx_en = ~tx_en;
            if ($urandom_range(0, 49) == 0) rx_en = ~rx_en;
            cfg_we = ($urandom_range(0, 299) == 0);
            cfg_wdata = 8'($urandom);
        end
        @(negedge clk); #1; cfg_we = 1'b0;
        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule